// File: doc/BRIEF.md
# Spike Event Feature Binner

The binner turns a stream of address-event spikes from a multi-channel auditory sensor into a fixed-size feature vector of spike counts. Every event presents a channel address with a valid strobe. Within the current bin, the block keeps one saturating counter for each channel. A bin closes on one of two rules, chosen by a mode input: a fixed number of clock ticks has passed, or a fixed number of accepted spikes has been counted across all channels. Ten bins make up a vector. When a sample runs long, bins after the tenth are dropped. When a sample runs short, the bins it never reached stay zero. The block keeps no raw events and no timestamps.

A controller loads the bin width (in ticks) or the spike limit, pulses `sample_start` to begin, and may pulse `sample_end` when the utterance finishes. As an example, a 40 ms width is 2,000,000 ticks at 50 MHz, and a typical count limit is 400. When `done` is high, the counts are read through a flat, bin-major index and return one cycle later.

Top module: `spike_binner`

## Requirements
- R1: Reset or a `sample_start` pulse clears every counter to zero and drives `done` low. An event presented in the same cycle as `sample_start` is not counted.
- R2: Only events with `ev_addr` below 54 are counted. Events at addresses 54..63 change no counter and do not add to the count-mode spike total.
- R3: Counter read index = bin × 54 + channel, with bins 0..9. `rd_data` shows the addressed count one cycle after `rd_idx` is applied. An index of 540 or more reads 0.
- R4: With `mode` = 0 (time), bin k receives the events accepted in clock cycles k×T+1 .. (k+1)×T after the `sample_start` cycle, where T is the programmed tick width (0 acts as 1).
- R5: With `mode` = 1 (count), a bin closes on the accepted event that brings its spike total to the programmed limit L (0 acts as 1). That event is counted in the closing bin. Cycles with no event never close a bin.
- R6: When the tenth bin closes, `done` rises in the following cycle, and every later event of that sample is discarded.
- R7: A `sample_end` pulse during a sample keeps the partial bin's counts. All bins the sample did not reach read zero.
- R8: `done` is high in the cycle after a `sample_end` that arrives during a sample. It stays high until the next `sample_start`, and events seen while it is high are ignored.
- R9: Each counter saturates at 255 rather than wrapping.
- R10: `mode`, the tick width and the count limit are captured at `sample_start`. Changes to them during a sample have no effect on that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Boundary rule: 0 = elapsed ticks, 1 = spike total |
| cfg_ticks | input | 24 | Time-mode bin width in clock ticks |
| cfg_limit | input | 16 | Count-mode spikes per bin |
| sample_start | input | 1 | Pulse: clear counters, capture config, begin sample |
| sample_end | input | 1 | Pulse: close partial bin and finish sample |
| ev_valid | input | 1 | Event strobe |
| ev_addr | input | 6 | Event channel address |
| rd_idx | input | 10 | Flat bin-major counter index |
| rd_data | output | 8 | Registered count at `rd_idx` |
| done | output | 1 | Feature vector final |

## Verification
Bin boundaries can only be observed indirectly. A count reveals which bin it landed in through the read index, so the bench places single spikes on the cycle just before and just after each expected edge and then reads both neighbouring bins. Count-mode closure is stressed the same way. Spikes at addresses 54 and 63 are inserted between valid ones, and a filter leak would shift the following valid spike into the next bin. The tenth-bin truncation edge is reached quickly by programming a two-tick width. A spike is then placed on the final cycle of bin 9 and another one cycle later.

// File: rtl/spike_binner_pkg.sv
package spike_binner_pkg;
  typedef enum logic {
    BIN_BY_TIME  = 1'b0,
    BIN_BY_COUNT = 1'b1
  } bin_mode_e;
endpackage

// File: rtl/sb_event_gate.sv
// Accepts an event only when it is strobed and its address names a live channel.
module sb_event_gate #(
  parameter int ADDR_W   = 6,
  parameter int CHANNELS = 54
) (
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] CH_LIM = (ADDR_W+1)'(CHANNELS);

  assign hit = ev_valid && ({1'b0, ev_addr} < CH_LIM);
endmodule

// File: rtl/sb_bin_sequencer.sv
// Tracks the open bin and decides when it closes, by ticks or by spike total.
module sb_bin_sequencer
  import spike_binner_pkg::*;
#(
  parameter int BINS    = 10,
  parameter int TICK_W  = 24,
  parameter int LIMIT_W = 16,
  parameter int BIN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop,
  input  logic               mode,
  input  logic [TICK_W-1:0]  cfg_ticks,
  input  logic [LIMIT_W-1:0] cfg_limit,
  input  logic               hit,
  output logic               active,
  output logic [BIN_W-1:0]   bin_idx,
  output logic               done
);
  localparam logic [TICK_W:0]  TICK_ONE = (TICK_W+1)'(1);
  localparam logic [LIMIT_W:0] LIM_ONE  = (LIMIT_W+1)'(1);
  localparam logic [BIN_W-1:0] BIN_ONE  = BIN_W'(1);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(BINS-1);

  bin_mode_e          mode_q;
  logic [TICK_W-1:0]  ticks_q, tick_q;
  logic [LIMIT_W-1:0] limit_q, total_q;
  logic [BIN_W-1:0]   bin_q;
  logic               active_q, done_q;

  logic [TICK_W:0]  tick_nx;
  logic [LIMIT_W:0] total_nx;
  logic             close_time, close_cnt, close_bin;

  always_comb begin
    tick_nx    = {1'b0, tick_q} + TICK_ONE;
    total_nx   = {1'b0, total_q} + LIM_ONE;
    close_time = (mode_q == BIN_BY_TIME) && (tick_nx >= {1'b0, ticks_q});
    close_cnt  = (mode_q == BIN_BY_COUNT) && hit && (total_nx >= {1'b0, limit_q});
    close_bin  = close_time || close_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= BIN_BY_TIME;
      ticks_q  <= '0;
      limit_q  <= '0;
      tick_q   <= '0;
      total_q  <= '0;
      bin_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start) begin
      mode_q   <= bin_mode_e'(mode);
      ticks_q  <= cfg_ticks;
      limit_q  <= cfg_limit;
      tick_q   <= '0;
      total_q  <= '0;
      bin_q    <= '0;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (active_q) begin
      if (mode_q == BIN_BY_TIME)
        tick_q <= close_time ? '0 : tick_nx[TICK_W-1:0];
      if (mode_q == BIN_BY_COUNT && hit)
        total_q <= close_cnt ? '0 : total_nx[LIMIT_W-1:0];
      if (stop) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else if (close_bin) begin
        bin_q <= bin_q + BIN_ONE;
        if (bin_q == BIN_LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign active  = active_q;
  assign bin_idx = bin_q;
  assign done    = done_q;
endmodule

// File: rtl/sb_count_store.sv
// Bin-major array of saturating counters with one registered read port.
module sb_count_store #(
  parameter int BINS     = 10,
  parameter int CHANNELS = 54,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = 8,
  parameter int BIN_W    = 4,
  parameter int ENT_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              inc,
  input  logic [BIN_W-1:0]  bin_idx,
  input  logic [ADDR_W-1:0] chan,
  input  logic [ENT_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int             ENTRIES = BINS * CHANNELS;
  localparam logic [ENT_W:0] ENT_LIM = (ENT_W+1)'(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [ENT_W-1:0] sel;
  logic [CNT_W-1:0] rd_q;

  assign sel = ENT_W'(bin_idx) * ENT_W'(CHANNELS) + ENT_W'(chan);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clear)
        cnt_q[e] <= '0;
      else if (inc && sel == ENT_W'(e) && cnt_q[e] != CNT_MAX)
        cnt_q[e] <= cnt_q[e] + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if ({1'b0, rd_idx} < ENT_LIM)
      rd_q <= cnt_q[rd_idx];
    else
      rd_q <= '0;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/spike_binner.sv
module spike_binner #(
  parameter int CHANNELS = 54,
  parameter int ADDR_W   = 6,
  parameter int BINS     = 10,
  parameter int CNT_W    = 8,
  parameter int TICK_W   = 24,
  parameter int LIMIT_W  = 16,
  parameter int ENT_W    = $clog2(BINS * CHANNELS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode,
  input  logic [TICK_W-1:0]  cfg_ticks,
  input  logic [LIMIT_W-1:0] cfg_limit,
  input  logic               sample_start,
  input  logic               sample_end,
  input  logic               ev_valid,
  input  logic [ADDR_W-1:0]  ev_addr,
  input  logic [ENT_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]   rd_data,
  output logic               done
);
  localparam int BIN_W = $clog2(BINS + 1);

  logic             hit, seq_active, count_en;
  logic [BIN_W-1:0] bin_idx;

  sb_event_gate #(.ADDR_W(ADDR_W), .CHANNELS(CHANNELS)) u_gate (
    .ev_valid (ev_valid),
    .ev_addr  (ev_addr),
    .hit      (hit)
  );

  sb_bin_sequencer #(
    .BINS(BINS), .TICK_W(TICK_W), .LIMIT_W(LIMIT_W), .BIN_W(BIN_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (sample_start),
    .stop      (sample_end),
    .mode      (mode),
    .cfg_ticks (cfg_ticks),
    .cfg_limit (cfg_limit),
    .hit       (hit),
    .active    (seq_active),
    .bin_idx   (bin_idx),
    .done      (done)
  );

  assign count_en = seq_active && hit;

  sb_count_store #(
    .BINS(BINS), .CHANNELS(CHANNELS), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .BIN_W(BIN_W), .ENT_W(ENT_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clear   (sample_start),
    .inc     (count_en),
    .bin_idx (bin_idx),
    .chan    (ev_addr),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int BINS     = 10,
  parameter int CHANNELS = 54,
  parameter int ADDR_W   = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_start,
  input logic                       sample_end,
  input logic                       ev_valid,
  input logic [ADDR_W-1:0]          ev_addr,
  input logic                       done,
  input logic                       active,
  input logic [$clog2(BINS+1)-1:0]  bin_idx,
  input logic                       count_en
);
  localparam int BW = $clog2(BINS + 1);
  localparam logic [BW-1:0]     BIN_MAX = BW'(BINS);
  localparam logic [BW-1:0]     BIN_ONE = BW'(1);
  localparam logic [ADDR_W:0]   CH_LIM  = (ADDR_W+1)'(CHANNELS);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> (!done && bin_idx == '0));

  assert_filter_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && {1'b0, ev_addr} >= CH_LIM) |-> !count_en);

  assert_bin_step_R4: assert property (@(posedge clk) disable iff (rst)
    !sample_start |=> (bin_idx == $past(bin_idx) || bin_idx == $past(bin_idx) + BIN_ONE));

  assert_bin_bound_R6: assert property (@(posedge clk) disable iff (rst)
    bin_idx <= BIN_MAX);

  assert_no_count_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !count_en);

  assert_end_done_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_end && active && !sample_start) |=> done);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !sample_start) |=> done);
endmodule

bind spike_binner sb_checker #(
  .BINS(BINS), .CHANNELS(CHANNELS), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_start (sample_start),
  .sample_end   (sample_end),
  .ev_valid     (ev_valid),
  .ev_addr      (ev_addr),
  .done         (done),
  .active       (seq_active),
  .bin_idx      (bin_idx),
  .count_en     (count_en)
);

// File: tb/tb_spike_binner.sv
module tb_spike_binner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic [23:0] cfg_ticks = '0;
  logic [15:0] cfg_limit = '0;
  logic        sample_start = 1'b0, sample_end = 1'b0;
  logic        ev_valid = 1'b0;
  logic [5:0]  ev_addr = '0;
  logic [9:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spike_binner dut (
    .clk(clk), .rst(rst), .mode(mode), .cfg_ticks(cfg_ticks), .cfg_limit(cfg_limit),
    .sample_start(sample_start), .sample_end(sample_end), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  function automatic int ix(int b, int c);
    return b * 54 + c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ev(bit v, int a);
    ev_valid = v;
    ev_addr  = 6'(a);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_sample(bit m, int ticks, int lim);
    mode = m; cfg_ticks = 24'(ticks); cfg_limit = 16'(lim);
    sample_start = 1'b1;
    @(negedge clk);
    sample_start = 1'b0;
  endtask

  task automatic end_sample();
    sample_end = 1'b1;
    @(negedge clk);
    sample_end = 1'b0;
  endtask

  task automatic rd(int idx, output int v);
    rd_idx = 10'(idx);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 done after reset", int'(done), 0);
    rd(ix(0, 0), v); chk("R1 counter after reset", v, 0);
    rd(540, v);      chk("R3 out-of-range read", v, 0);
  endtask

  task automatic t_time_bins();
    int v;
    begin_sample(1'b0, 4, 0);
    ev(1, 3); idle(2); ev(1, 3);   // cycles 1 and 4: bin 0
    ev(1, 5);                       // cycle 5: bin 1
    idle(6); ev(1, 7);              // cycle 12: bin 2
    chk("R8 done low mid-sample", int'(done), 0);
    end_sample();
    chk("R8 done after end", int'(done), 1);
    rd(ix(0, 3), v); chk("R4 bin0 ch3", v, 2);
    rd(ix(1, 3), v); chk("R4 bin1 ch3", v, 0);
    rd(ix(1, 5), v); chk("R4 bin1 ch5", v, 1);
    rd(ix(2, 7), v); chk("R4 bin2 ch7", v, 1);
    rd(ix(3, 7), v); chk("R3 bin3 ch7", v, 0);
  endtask

  task automatic t_time_trunc();
    int v;
    begin_sample(1'b0, 2, 0);
    idle(19);
    chk("R6 done before tenth bin", int'(done), 0);
    ev(1, 1);                       // cycle 20: last cycle of bin 9
    chk("R6 done after tenth bin", int'(done), 1);
    ev(1, 1);                       // discarded
    rd(ix(9, 1), v); chk("R6 bin9 ch1", v, 1);
  endtask

  task automatic t_count_bins();
    int v;
    begin_sample(1'b1, 0, 3);
    ev(1, 1); ev(1, 2); ev(1, 1);   // bin 0 closes
    ev(1, 4); idle(3);
    ev(1, 54); ev(1, 63);           // ignored, not in total
    ev(1, 4); ev(1, 4);             // bin 1 closes
    ev(1, 9);                       // bin 2
    end_sample();
    rd(ix(0, 1), v); chk("R5 bin0 ch1", v, 2);
    rd(ix(0, 2), v); chk("R5 bin0 ch2", v, 1);
    rd(ix(1, 4), v); chk("R5 bin1 ch4", v, 3);
    rd(ix(2, 9), v); chk("R2 bin2 ch9 (filtered not in total)", v, 1);
    rd(ix(2, 0), v); chk("R2 no alias at bin2 ch0", v, 0);
    rd(ix(1, 0), v); chk("R2 no alias at bin1 ch0", v, 0);
  endtask

  task automatic t_count_trunc();
    int v;
    begin_sample(1'b1, 0, 1);
    for (int i = 0; i < 9; i++) ev(1, 20);
    chk("R6 done after nine bins", int'(done), 0);
    ev(1, 20);
    chk("R6 done after ten bins", int'(done), 1);
    ev(1, 20);
    rd(ix(9, 20), v); chk("R6 bin9 ch20", v, 1);
    rd(ix(0, 20), v); chk("R5 bin0 ch20", v, 1);
  endtask

  task automatic t_partial();
    int v;
    begin_sample(1'b1, 0, 5);
    ev(1, 0); ev(1, 0);
    end_sample();
    chk("R8 done after partial end", int'(done), 1);
    idle(5);
    chk("R8 done held", int'(done), 1);
    ev(1, 0);
    rd(ix(0, 0), v); chk("R7 partial bin kept", v, 2);
    for (int b = 1; b < 10; b++) begin
      rd(ix(b, 0), v);  chk("R7 padded ch0", v, 0);
      rd(ix(b, 53), v); chk("R7 padded ch53", v, 0);
    end
  endtask

  task automatic t_saturate();
    int v;
    begin_sample(1'b0, 1000, 0);
    repeat (300) ev(1, 10);
    end_sample();
    rd(ix(0, 10), v); chk("R9 saturated count", v, 255);
  endtask

  task automatic t_cfg_capture();
    int v;
    begin_sample(1'b1, 0, 2);
    cfg_limit = 16'd100; mode = 1'b0; cfg_ticks = 24'd1;
    ev(1, 0); idle(4); ev(1, 0); idle(4); ev(1, 1);
    end_sample();
    rd(ix(0, 0), v); chk("R10 bin0 ch0", v, 2);
    rd(ix(1, 1), v); chk("R10 bin1 ch1", v, 1);
  endtask

  task automatic t_restart();
    int v;
    ev_valid = 1'b1; ev_addr = 6'd10;
    begin_sample(1'b0, 8, 0);       // event in start cycle
    ev_valid = 1'b0;
    chk("R1 done cleared by start", int'(done), 0);
    rd(ix(0, 10), v); chk("R1 start clears and ignores", v, 0);
    rd(ix(1, 1), v);  chk("R1 old counts cleared", v, 0);
    end_sample();
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_time_bins();
    t_time_trunc();
    t_count_bins();
    t_count_trunc();
    t_partial();
    t_saturate();
    t_cfg_capture();
    t_restart();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule